// File: doc/BRIEF.md
# Cartridge ROM Bank Switching Controller

This block translates addresses for a game-console cartridge. Every CPU write in the upper 32 KiB of the 16-bit CPU address space is a register access. Only address bit 0 is decoded. An even address writes a 3-bit pointer, and an odd address writes a value into whichever of eight bank registers the pointer names. The pattern repeats across the whole upper half, so every even/odd address pair in it aliases the same two ports. Reads never touch any register.

The program-ROM side splits the upper 32 KiB into four 8 KiB windows. The lowest two windows follow bank registers 6 and 7. The highest two are fixed to the second-to-last and last banks of the ROM, so the reset vector is always served from the last bank. The character-ROM side splits the 8 KiB video pattern space in two. The lower 4 KiB is covered by two 2 KiB windows (registers 0 and 1, stored bit 0 ignored). The upper 4 KiB is covered by four 1 KiB windows (registers 2 to 5). Bank numbers wrap modulo the ROM size. Both translated addresses leave through output registers.

Top module: `cart_bank_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the pointer, all eight bank registers and both outputs to 0. After reset, CPU address 0xFFFC translates to the last 8 KiB bank at offset 0x1FFC.
- R2: A write (`cpu_wr`=1) with `cpu_addr[15]`=1 and `cpu_addr[0]`=0 loads the pointer with `cpu_data[2:0]`. All other address bits are ignored.
- R3: A write with `cpu_addr[15]`=1 and `cpu_addr[0]`=1 loads the bank register named by the pointer. Registers 0 to 5 take `cpu_data[5:0]`. Registers 6 and 7 take `cpu_data[3:0]`, with the upper bits cleared.
- R4: A cycle with `cpu_wr`=0, or with `cpu_addr[15]`=0, changes no register.
- R5: For `cpu_addr[14:13]` equal to 0 or 1, `prg_addr` = {register 6 or 7 respectively mod PRG_BANKS, `cpu_addr[12:0]`}.
- R6: For `cpu_addr[14:13]` equal to 2 or 3, the bank field of `prg_addr` is PRG_BANKS-2 or PRG_BANKS-1 respectively.
- R7: For `ppu_addr[12]`=0, `ppu_addr[11]` selects register 0 or 1. The 1 KiB bank number is {register[5:1], `ppu_addr[10]`}.
- R8: For `ppu_addr[12]`=1, `ppu_addr[11:10]` values 0 to 3 select registers 2 to 5 as the 1 KiB bank number.
- R9: `chr_addr` = {bank number mod CHR_BANKS, `ppu_addr[9:0]`}.
- R10: Both outputs are registered. The value after a clock edge reflects the inputs sampled at that edge and the register contents held before it, so a bank write is seen only from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 13 | Video pattern-space address |
| prg_addr | output | clog2(PRG_BANKS)+13 | Translated program-ROM address |
| chr_addr | output | clog2(CHR_BANKS)+10 | Translated character-ROM address |

## Verification
The bench builds the block with PRG_BANKS=8 and CHR_BANKS=32, both smaller than the 4-bit and 6-bit register fields. This makes the modulo wrap of stored bank numbers visible at the outputs. It also moves the fixed windows to banks 6 and 7, so the fixed-bank arithmetic is not mistaken for the all-ones field width. Directed sequences cover aliased register addresses, ignored low-half writes and the same-cycle write-versus-read ordering. A long random run is then compared against a behavioural model on every clock.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int NUM_BANK_REGS = 8;
  localparam int SEL_W         = $clog2(NUM_BANK_REGS);
  localparam int BANK_REG_W    = 6;
  localparam int PRG_REG_W     = 4;
  localparam int CPU_AW        = 16;
  localparam int CPU_DW        = 8;
  localparam int PPU_AW        = 13;
  localparam int PRG_PAGE_W    = 13;
  localparam int CHR_PAGE_W    = 10;
  localparam int NUM_CHR_REGS  = 6;

  typedef logic [BANK_REG_W-1:0] bank_val_t;
  typedef bank_val_t [NUM_BANK_REGS-1:0] bank_file_t;

  typedef enum logic [SEL_W-1:0] {
    BR_CHR_LO_A = 3'd0,
    BR_CHR_LO_B = 3'd1,
    BR_CHR_HI_0 = 3'd2,
    BR_CHR_HI_1 = 3'd3,
    BR_CHR_HI_2 = 3'd4,
    BR_CHR_HI_3 = 3'd5,
    BR_PRG_A    = 3'd6,
    BR_PRG_B    = 3'd7
  } bank_idx_t;
endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_odd,
  input  logic [BANK_REG_W-1:0] wr_data,
  output bank_file_t            banks
);
  localparam bank_val_t PRG_KEEP = bank_val_t'((1 << PRG_REG_W) - 1);
  localparam bank_val_t CHR_KEEP = '1;

  logic [SEL_W-1:0] sel_q;
  bank_file_t       bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_en && !wr_odd) begin
      sel_q <= wr_data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
    end else if (wr_en && wr_odd) begin
      for (int i = 0; i < NUM_BANK_REGS; i++) begin
        if (sel_q == SEL_W'(i)) begin
          if (i >= int'(BR_PRG_A)) bank_q[i] <= wr_data & PRG_KEEP;
          else                     bank_q[i] <= wr_data & CHR_KEEP;
        end
      end
    end
  end

  assign banks = bank_q;

  // R2: pointer takes the low data bits of an even-address write
  p_sel_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_odd) |=> sel_q == $past(wr_data[SEL_W-1:0]));

  // R4: nothing changes without a qualified write
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(sel_q) && $stable(bank_q)));

  // R3: a data write alters at most the one addressed register, never the pointer
  p_data_one_reg_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_odd) |=> ($stable(sel_q) &&
      $countones({bank_q[7] != $past(bank_q[7]), bank_q[6] != $past(bank_q[6]),
                  bank_q[5] != $past(bank_q[5]), bank_q[4] != $past(bank_q[4]),
                  bank_q[3] != $past(bank_q[3]), bank_q[2] != $past(bank_q[2]),
                  bank_q[1] != $past(bank_q[1]), bank_q[0] != $past(bank_q[0])}) <= 1));
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
  import cart_bank_pkg::*;
#(
  parameter int PRG_BANKS = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [CPU_AW-2:0]                    cpu_addr,
  input  logic [PRG_REG_W-1:0]                 bank_a,
  input  logic [PRG_REG_W-1:0]                 bank_b,
  output logic [$clog2(PRG_BANKS)+PRG_PAGE_W-1:0] prg_addr
);
  localparam int PRG_BW = $clog2(PRG_BANKS);
  localparam int PRG_AW = PRG_BW + PRG_PAGE_W;
  localparam logic [PRG_BW-1:0] BANK_LAST = PRG_BW'(PRG_BANKS - 1);
  localparam logic [PRG_BW-1:0] BANK_NEXT = PRG_BW'(PRG_BANKS - 2);

  logic [1:0]        window;
  logic [PRG_BW-1:0] bank_sel;
  logic [PRG_AW-1:0] prg_q;

  assign window = cpu_addr[CPU_AW-2:PRG_PAGE_W];

  always_comb begin
    unique case (window)
      2'd0:    bank_sel = PRG_BW'(bank_a);
      2'd1:    bank_sel = PRG_BW'(bank_b);
      2'd2:    bank_sel = BANK_NEXT;
      default: bank_sel = BANK_LAST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prg_q <= '0;
    else     prg_q <= {bank_sel, cpu_addr[PRG_PAGE_W-1:0]};
  end

  assign prg_addr = prg_q;

  // R6: top window always the last bank
  p_fixed_last_r6: assert property (@(posedge clk) disable iff (rst)
    (window == 2'd3) |=> prg_addr[PRG_AW-1:PRG_PAGE_W] == BANK_LAST);

  // R6: third window always the second-to-last bank
  p_fixed_next_r6: assert property (@(posedge clk) disable iff (rst)
    (window == 2'd2) |=> prg_addr[PRG_AW-1:PRG_PAGE_W] == BANK_NEXT);

  // R5: page offset passes straight through one cycle later
  p_offset_pass_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prg_addr[PRG_PAGE_W-1:0] == $past(cpu_addr[PRG_PAGE_W-1:0]));
endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map
  import cart_bank_pkg::*;
#(
  parameter int CHR_BANKS = 64
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [PPU_AW-1:0]                       ppu_addr,
  input  logic [NUM_CHR_REGS-1:0][BANK_REG_W-1:0] chr_banks,
  output logic [$clog2(CHR_BANKS)+CHR_PAGE_W-1:0] chr_addr
);
  localparam int CHR_BW = $clog2(CHR_BANKS);
  localparam int CHR_AW = CHR_BW + CHR_PAGE_W;

  logic              upper_half;
  bank_val_t         lo_reg;
  bank_val_t         hi_reg;
  bank_val_t         bank_1k;
  logic [CHR_AW-1:0] chr_q;
  logic              unused_lsb;

  assign upper_half = ppu_addr[PPU_AW-1];
  assign lo_reg     = ppu_addr[11] ? chr_banks[1] : chr_banks[0];
  assign hi_reg     = chr_banks[2 + int'(ppu_addr[11:10])];
  assign unused_lsb = lo_reg[0];

  always_comb begin
    if (upper_half) bank_1k = hi_reg;
    else            bank_1k = {lo_reg[BANK_REG_W-1:1], ppu_addr[10]};
  end

  always_ff @(posedge clk) begin
    if (rst) chr_q <= '0;
    else     chr_q <= {CHR_BW'(bank_1k), ppu_addr[CHR_PAGE_W-1:0]};
  end

  assign chr_addr = chr_q;

  // R7: 2 KiB windows take their low bank bit from the video address
  p_lo_even_r7: assert property (@(posedge clk) disable iff (rst)
    !ppu_addr[PPU_AW-1] |=> chr_addr[CHR_PAGE_W] == $past(ppu_addr[10]));

  // R9: page offset passes straight through one cycle later
  p_offset_pass_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> chr_addr[CHR_PAGE_W-1:0] == $past(ppu_addr[CHR_PAGE_W-1:0]));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 64
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [15:0]                             cpu_addr,
  input  logic [7:0]                              cpu_data,
  input  logic                                    cpu_wr,
  input  logic [12:0]                             ppu_addr,
  output logic [$clog2(PRG_BANKS)+PRG_PAGE_W-1:0] prg_addr,
  output logic [$clog2(CHR_BANKS)+CHR_PAGE_W-1:0] chr_addr
);
  logic       reg_hit;
  bank_file_t banks;
  logic       unused_bits;

  assign reg_hit     = cpu_wr && cpu_addr[CPU_AW-1];
  assign unused_bits = ^{cpu_data[CPU_DW-1:BANK_REG_W],
                         banks[BR_PRG_A][BANK_REG_W-1:PRG_REG_W],
                         banks[BR_PRG_B][BANK_REG_W-1:PRG_REG_W]};

  cart_bank_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_hit),
    .wr_odd  (cpu_addr[0]),
    .wr_data (cpu_data[BANK_REG_W-1:0]),
    .banks   (banks)
  );

  cart_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr[CPU_AW-2:0]),
    .bank_a   (banks[BR_PRG_A][PRG_REG_W-1:0]),
    .bank_b   (banks[BR_PRG_B][PRG_REG_W-1:0]),
    .prg_addr (prg_addr)
  );

  cart_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .clk       (clk),
    .rst       (rst),
    .ppu_addr  (ppu_addr),
    .chr_banks (banks[NUM_CHR_REGS-1:0]),
    .chr_addr  (chr_addr)
  );

  // R1: outputs leave reset cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (prg_addr == '0 && chr_addr == '0));
endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb_top;
  localparam int PB = 8;
  localparam int CB = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [12:0] ppu_addr = '0;
  logic [15:0] prg_addr;
  logic [14:0] chr_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit cmp_on = 0;
  string phase = "R1";

  // behavioural reference state
  int m_sel = 0;
  int m_reg [8];
  int exp_prg = 0;
  int exp_chr = 0;
  string prg_tag = "R1";
  string chr_tag = "R1";

  always #2.5 clk = ~clk;

  cart_bank_ctrl #(.PRG_BANKS(PB), .CHR_BANKS(CB)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
      exp_prg = 0;
      exp_chr = 0;
      prg_tag = "R1";
      chr_tag = "R1";
    end else begin
      int w, pb, cb, r, a, p;
      a = int'(cpu_addr);
      p = int'(ppu_addr);
      w = (a / 8192) % 4;
      if (w == 0)      pb = m_reg[6];
      else if (w == 1) pb = m_reg[7];
      else if (w == 2) pb = PB - 2;
      else             pb = PB - 1;
      exp_prg = (pb % PB) * 8192 + (a % 8192);
      prg_tag = (w < 2) ? "R5" : "R6";
      if (p < 4096) begin
        r  = m_reg[(p / 2048) % 2];
        cb = (r / 2) * 2 + ((p / 1024) % 2);
        chr_tag = "R7";
      end else begin
        cb = m_reg[2 + (p / 1024) % 4];
        chr_tag = "R8";
      end
      exp_chr = (cb % CB) * 1024 + (p % 1024);
      if (cpu_wr && a >= 32768) begin
        if (a % 2 == 0) m_sel = int'(cpu_data) % 8;
        else m_reg[m_sel] = (m_sel >= 6) ? int'(cpu_data) % 16 : int'(cpu_data) % 64;
      end
    end
  end

  task automatic check(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check({phase, "/", prg_tag, "/R10"}, "prg_addr model", int'(prg_addr), exp_prg);
      check({phase, "/", chr_tag, "/R9"},  "chr_addr model", int'(chr_addr), exp_chr);
    end
  end

  task automatic tick(bit wr, int addr, int data, int paddr);
    cpu_wr   = wr;
    cpu_addr = 16'(addr);
    cpu_data = 8'(data);
    ppu_addr = 13'(paddr);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "prg in reset", int'(prg_addr), 0);
    check("R1", "chr in reset", int'(chr_addr), 0);
    rst = 1'b0;
    cmp_on = 1;

    // R1 / R6: reset vector and fixed windows
    tick(0, 16'hFFFC, 0, 0);
    check("R1", "reset vector", int'(prg_addr), 16'hFFFC);
    tick(0, 16'hC123, 0, 0);
    check("R6", "second-to-last window", int'(prg_addr), 16'hC123);
    tick(0, 16'h8005, 0, 0);
    check("R5", "cleared reg6", int'(prg_addr), 16'h0005);

    // R2 / R3: pointer then data, PRG keeps 4 bits, mod 8
    phase = "R3";
    tick(1, 16'h8000, 6, 0);
    tick(1, 16'h8001, 8'h3D, 0);
    tick(0, 16'h8010, 0, 0);
    check("R3", "prg reg keeps 4 bits", int'(prg_addr), 16'hA010);

    // R2 aliases across the upper half; R7 2 KiB lsb ignored
    phase = "R2";
    tick(1, 16'hF2AA, 8'hF9, 0);
    tick(1, 16'hBEEF, 8'h2B, 0);
    tick(0, 16'h0000, 0, 13'h0800);
    check("R7", "2k window low half", int'(chr_addr), 16'h2800);
    tick(0, 16'h0000, 0, 13'h0C07);
    check("R7", "2k window high half", int'(chr_addr), 16'h2C07);

    // R4: low-half writes and upper-half reads are ignored
    phase = "R4";
    tick(1, 16'h7FFF, 8'h3F, 0);
    tick(1, 16'h7FFE, 8'h07, 0);
    tick(0, 16'h8001, 8'h00, 0);
    tick(0, 16'h8010, 0, 13'h0800);
    check("R4", "prg after ignored writes", int'(prg_addr), 16'hA010);
    check("R4", "chr after ignored writes", int'(chr_addr), 16'h2800);

    // R8 / R9: 1 KiB window and modulo wrap
    phase = "R8";
    tick(1, 16'h8000, 4, 0);
    tick(1, 16'h8001, 8'h17, 0);
    tick(0, 16'h0000, 0, 13'h1805);
    check("R8", "1k window", int'(chr_addr), 16'h5C05);
    tick(1, 16'hD001, 8'h3F, 0);
    tick(0, 16'h0000, 0, 13'h1805);
    check("R9", "bank wraps mod CHR size", int'(chr_addr), 16'h7C05);

    // R10: same-cycle write sees old bank
    phase = "R10";
    tick(1, 16'h8000, 7, 0);
    tick(1, 16'hA001, 3, 0);
    check("R10", "write cycle uses old bank", int'(prg_addr), 16'h0001);
    tick(0, 16'hA001, 0, 0);
    check("R10", "next cycle uses new bank", int'(prg_addr), 16'h6001);

    // random run compared on every clock
    phase = "RND";
    for (int k = 0; k < 4000; k++) begin
      int a;
      a = int'($urandom_range(0, 65535));
      if ($urandom_range(0, 3) != 0) a = a | 32768;
      tick($urandom_range(0, 9) < 4, a, int'($urandom_range(0, 255)),
           int'($urandom_range(0, 8191)));
    end

    tick(0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule